// File: doc/BRIEF.md
# Inclusive L2 Line Coherence Controller

This block is the per-line state machine of an inclusive shared second-level cache bank. That bank keeps track of several private first-level caches under a MESI-style protocol. An external classifier turns each incoming message or local decision into one event code. The controller accepts at most one event per cycle. It registers the line's next state, together with a vector of action strobes that tells the surrounding bank what to do: reply with data, reply with exclusive data, forward to the owning L1, invalidate the sharers, fetch from memory, write back to memory, send an acknowledge, stall the event, pop the input queue, or wake dependent requests.

The controller tells apart a line that is modified in the L2 from a line that an L1 holds modified, where the L2 copy is stale. It has fetch states and blocking states that hold off new requests until memory data or the requester's unblock arrives. It also has replacement states that collect invalidation acks or data before waiting for the memory acknowledge.

Events arrive on a valid/ready input. `ev_ready` is low during reset and for the first cycle after reset, and high from then on. The block never back-pressures once it is running. The result side has no back-pressure: `act_valid` is a one-cycle pulse that the bank must consume.

Top module: `l2_line_coh_ctrl`

## Requirements
- R1: After reset, `line_state` is 0 (not present), `act_valid` and `proto_err` are low, and `ev_ready` is high from the second clock edge after reset is released. Asserting reset again clears a set `proto_err`.
- R2: Each event accepted on a rising edge (`ev_valid` and `ev_ready`) gives `act_valid` high for exactly the following cycle, together with the new `line_state`. Without an accepted event, `act_valid` is low, `act_strb` is 0 and `line_state` holds. Strobe bits: 0 data, 1 exclusive data, 2 forward to owner, 3 invalidate sharers, 4 memory fetch, 5 memory writeback, 6 ack, 7 stall, 8 pop, 9 wake.
- R3: In state 0, event codes select the fetch state and raise fetch and pop: data read (code 0) goes to 4, instruction read (code 1) goes to 5, and write (code 2) goes to 6.
- R4: In state 4, a data or instruction read goes to state 5 with pop. In state 5, reads pop and stay. Memory data (code 6) in state 5 gives data, pop and wake, and the line goes to shared (state 1).
- R5: Memory data in state 4 gives exclusive data and pop. Memory data in state 6 gives data and pop. Both go to blocked state 9. An exclusive unblock (code 12) in a blocked state (7, 8 or 9) gives pop and wake and goes to owned-by-L1 (state 3). A write (code 2) in modified (state 2) gives exclusive data and pop and goes to state 8.
- R6: A read in state 3 gives forward and pop and goes to 10. Unblock (code 11) then leads to 11, and L1 data (code 8) then leads to 12. The other event, in either order, gives pop and wake and goes to shared (state 1).
- R7: An L1 writeback (code 3) in state 3 gives ack and pop and goes to modified (state 2).
- R8: Replacement: dirty (code 4) or clean (code 5) in state 2 goes to 13 with writeback or ack respectively. In state 1, code 4 goes to 15 and code 5 goes to 14, with invalidate. In state 3, code 4 goes to 16 and code 5 goes to 17, with invalidate. A non-final ack (code 9) pops. The final ack (code 10) or L1 data ends the collection in 13 with writeback, or with ack for clean lines (14, and 17 on final ack). Memory ack (code 7) in 13 gives pop and wake and returns to 0.
- R9: In fetch and blocking states (4 to 12), request events (codes 0 to 5) and directory invalidation (code 13) give stall only, and the state is unchanged. In replacement states (13 to 17), request events give stall only.
- R10: A directory invalidation (code 13) in a replacement state, or in state 0, gives pop only and leaves the state unchanged.
- R11: An event with no transition in the current state, including codes 14 and 15, sets `proto_err` until reset, leaves the state unchanged and gives `act_valid` with all strobes 0.
- R12: A read in shared (state 1) gives data and pop and stays. A write in shared gives exclusive data, invalidate and pop and goes to blocked state 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Controller can accept an event |
| ev_code | input | 4 | Classified event code |
| act_valid | output | 1 | Result of the last accepted event is present |
| act_strb | output | 10 | Action strobes |
| line_state | output | 5 | Current line state |
| proto_err | output | 1 | Sticky illegal-event flag |

## Verification
The assertions take for granted that the classifier presents `ev_valid` only with a stable code for that cycle. They do not assume that the sequence of events is legal: an illegal event must still leave the state frozen and set the error flag. The stimulus changes `ev_valid` and `ev_code` only on falling edges, after `ev_ready` has risen. It walks complete protocol transactions from not present back to not present, so every transient state is entered with a history that a real bank could produce. It deliberately injects illegal codes only in a dedicated segment that ends with a reset.

// File: rtl/l2ln_pkg.sv
package l2ln_pkg;
  localparam int ST_W  = 5;
  localparam int EV_W  = 4;
  localparam int ACT_W = 10;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 5'd0,
    ST_SHR     = 5'd1,
    ST_MOD     = 5'd2,
    ST_OWN     = 5'd3,
    ST_FX      = 5'd4,
    ST_FS      = 5'd5,
    ST_FM      = 5'd6,
    ST_SHR_BLK = 5'd7,
    ST_MOD_BLK = 5'd8,
    ST_OWN_BLK = 5'd9,
    ST_RD_W2   = 5'd10,
    ST_RD_WDAT = 5'd11,
    ST_RD_WUNB = 5'd12,
    ST_EV_MEM  = 5'd13,
    ST_EV_CLN  = 5'd14,
    ST_EV_DRT  = 5'd15,
    ST_EV_OWN  = 5'd16,
    ST_EV_OCL  = 5'd17
  } line_st_e;

  localparam logic [EV_W-1:0] EV_RD      = 4'd0;
  localparam logic [EV_W-1:0] EV_IFETCH  = 4'd1;
  localparam logic [EV_W-1:0] EV_WR      = 4'd2;
  localparam logic [EV_W-1:0] EV_PUT     = 4'd3;
  localparam logic [EV_W-1:0] EV_EVICT_D = 4'd4;
  localparam logic [EV_W-1:0] EV_EVICT_C = 4'd5;
  localparam logic [EV_W-1:0] EV_MDATA   = 4'd6;
  localparam logic [EV_W-1:0] EV_MACK    = 4'd7;
  localparam logic [EV_W-1:0] EV_L1DATA  = 4'd8;
  localparam logic [EV_W-1:0] EV_ACK     = 4'd9;
  localparam logic [EV_W-1:0] EV_ACKLAST = 4'd10;
  localparam logic [EV_W-1:0] EV_UNB     = 4'd11;
  localparam logic [EV_W-1:0] EV_XUNB    = 4'd12;
  localparam logic [EV_W-1:0] EV_DINV    = 4'd13;
  localparam int              EV_COUNT   = 14;

  localparam int A_DATA  = 0;
  localparam int A_EXCL  = 1;
  localparam int A_FWD   = 2;
  localparam int A_INV   = 3;
  localparam int A_FETCH = 4;
  localparam int A_WB    = 5;
  localparam int A_ACK   = 6;
  localparam int A_STALL = 7;
  localparam int A_POP   = 8;
  localparam int A_WAKE  = 9;

  localparam logic [ACT_W-1:0] M_DATA  = ACT_W'(1) << A_DATA;
  localparam logic [ACT_W-1:0] M_EXCL  = ACT_W'(1) << A_EXCL;
  localparam logic [ACT_W-1:0] M_FWD   = ACT_W'(1) << A_FWD;
  localparam logic [ACT_W-1:0] M_INV   = ACT_W'(1) << A_INV;
  localparam logic [ACT_W-1:0] M_FETCH = ACT_W'(1) << A_FETCH;
  localparam logic [ACT_W-1:0] M_WB    = ACT_W'(1) << A_WB;
  localparam logic [ACT_W-1:0] M_ACK   = ACT_W'(1) << A_ACK;
  localparam logic [ACT_W-1:0] M_STALL = ACT_W'(1) << A_STALL;
  localparam logic [ACT_W-1:0] M_POP   = ACT_W'(1) << A_POP;
  localparam logic [ACT_W-1:0] M_WAKE  = ACT_W'(1) << A_WAKE;
endpackage

// File: rtl/l2ln_ev_group.sv
module l2ln_ev_group
  import l2ln_pkg::*;
(
  input  logic [EV_W-1:0] ev,
  output logic            is_req,
  output logic            is_rd,
  output logic            known
);
  always_comb begin
    is_rd  = (ev == EV_RD) || (ev == EV_IFETCH);
    is_req = (ev <= EV_EVICT_C);
    known  = (int'(ev) < EV_COUNT);
  end
endmodule

// File: rtl/l2ln_next.sv
module l2ln_next
  import l2ln_pkg::*;
(
  input  line_st_e         cur,
  input  logic [EV_W-1:0]  ev,
  input  logic             is_req,
  input  logic             is_rd,
  input  logic             known,
  output line_st_e         nxt,
  output logic [ACT_W-1:0] act,
  output logic             bad
);
  logic is_dinv;
  assign is_dinv = (ev == EV_DINV);

  always_comb begin
    nxt = cur;
    act = '0;
    bad = 1'b0;
    if (!known) begin
      bad = 1'b1;
    end else begin
      case (cur)
        ST_IDLE: begin
          if (ev == EV_RD)          begin nxt = ST_FX; act = M_FETCH | M_POP; end
          else if (ev == EV_IFETCH) begin nxt = ST_FS; act = M_FETCH | M_POP; end
          else if (ev == EV_WR)     begin nxt = ST_FM; act = M_FETCH | M_POP; end
          else if (is_dinv)         act = M_POP;
          else                      bad = 1'b1;
        end
        ST_FX: begin
          if (is_rd)                    begin nxt = ST_FS; act = M_POP; end
          else if (ev == EV_MDATA)      begin nxt = ST_OWN_BLK; act = M_EXCL | M_POP; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_FS: begin
          if (is_rd)                    act = M_POP;
          else if (ev == EV_MDATA)      begin nxt = ST_SHR; act = M_DATA | M_POP | M_WAKE; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_FM: begin
          if (ev == EV_MDATA)           begin nxt = ST_OWN_BLK; act = M_DATA | M_POP; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_SHR_BLK, ST_MOD_BLK, ST_OWN_BLK: begin
          if (ev == EV_XUNB)            begin nxt = ST_OWN; act = M_POP | M_WAKE; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_SHR: begin
          if (is_rd)                    act = M_DATA | M_POP;
          else if (ev == EV_WR)         begin nxt = ST_SHR_BLK; act = M_EXCL | M_INV | M_POP; end
          else if (ev == EV_EVICT_D)    begin nxt = ST_EV_DRT; act = M_INV; end
          else if (ev == EV_EVICT_C)    begin nxt = ST_EV_CLN; act = M_INV; end
          else                          bad = 1'b1;
        end
        ST_MOD: begin
          if (ev == EV_RD)              begin nxt = ST_OWN_BLK; act = M_EXCL | M_POP; end
          else if (ev == EV_IFETCH)     begin nxt = ST_SHR; act = M_DATA | M_POP; end
          else if (ev == EV_WR)         begin nxt = ST_MOD_BLK; act = M_EXCL | M_POP; end
          else if (ev == EV_EVICT_D)    begin nxt = ST_EV_MEM; act = M_WB; end
          else if (ev == EV_EVICT_C)    begin nxt = ST_EV_MEM; act = M_ACK; end
          else                          bad = 1'b1;
        end
        ST_OWN: begin
          if (is_rd)                    begin nxt = ST_RD_W2; act = M_FWD | M_POP; end
          else if (ev == EV_WR)         begin nxt = ST_OWN_BLK; act = M_FWD | M_POP; end
          else if (ev == EV_PUT)        begin nxt = ST_MOD; act = M_ACK | M_POP; end
          else if (ev == EV_EVICT_D)    begin nxt = ST_EV_OWN; act = M_INV; end
          else if (ev == EV_EVICT_C)    begin nxt = ST_EV_OCL; act = M_INV; end
          else                          bad = 1'b1;
        end
        ST_RD_W2: begin
          if (ev == EV_UNB)             begin nxt = ST_RD_WDAT; act = M_POP; end
          else if (ev == EV_L1DATA)     begin nxt = ST_RD_WUNB; act = M_POP; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_RD_WDAT: begin
          if (ev == EV_L1DATA)          begin nxt = ST_SHR; act = M_POP | M_WAKE; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_RD_WUNB: begin
          if (ev == EV_UNB)             begin nxt = ST_SHR; act = M_POP | M_WAKE; end
          else if (is_req || is_dinv)   act = M_STALL;
          else                          bad = 1'b1;
        end
        ST_EV_MEM, ST_EV_CLN, ST_EV_DRT, ST_EV_OWN, ST_EV_OCL: begin
          if (is_req)                   act = M_STALL;
          else if (is_dinv)             act = M_POP;
          else if (ev == EV_ACK && cur != ST_EV_MEM) act = M_POP;
          else if (cur == ST_EV_MEM && ev == EV_MACK) begin
            nxt = ST_IDLE; act = M_POP | M_WAKE;
          end else if (cur == ST_EV_CLN && ev == EV_ACKLAST) begin
            nxt = ST_EV_MEM; act = M_ACK | M_POP;
          end else if (cur == ST_EV_OCL && ev == EV_ACKLAST) begin
            nxt = ST_EV_MEM; act = M_ACK | M_POP;
          end else if ((cur == ST_EV_DRT || cur == ST_EV_OWN) &&
                       (ev == EV_ACKLAST || ev == EV_L1DATA)) begin
            nxt = ST_EV_MEM; act = M_WB | M_POP;
          end else if (cur == ST_EV_OCL && ev == EV_L1DATA) begin
            nxt = ST_EV_MEM; act = M_WB | M_POP;
          end else                      bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/l2_line_coh_ctrl.sv
module l2_line_coh_ctrl
  import l2ln_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [EV_W-1:0]  ev_code,
  output logic             act_valid,
  output logic [ACT_W-1:0] act_strb,
  output logic [ST_W-1:0]  line_state,
  output logic             proto_err
);
  line_st_e         st_q, st_d;
  logic [ACT_W-1:0] act_d, act_q;
  logic             av_q, err_q, rdy_q, bad, is_req, is_rd, known, acc;

  assign acc = ev_valid && rdy_q;

  l2ln_ev_group u_grp (
    .ev(ev_code), .is_req(is_req), .is_rd(is_rd), .known(known)
  );

  l2ln_next u_nxt (
    .cur(st_q), .ev(ev_code), .is_req(is_req), .is_rd(is_rd), .known(known),
    .nxt(st_d), .act(act_d), .bad(bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      act_q <= '0;
      av_q  <= 1'b0;
      err_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      av_q  <= acc;
      act_q <= acc ? act_d : '0;
      if (acc) st_q <= st_d;
      if (acc && bad) err_q <= 1'b1;
    end
  end

  assign ev_ready   = rdy_q;
  assign act_valid  = av_q;
  assign act_strb   = act_q;
  assign line_state = st_q;
  assign proto_err  = err_q;

  AST_ACT_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> act_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_ready) |=> (!act_valid && act_strb == '0 && $stable(line_state))); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R11
  AST_BAD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && bad) |=> ($stable(line_state) && act_strb == '0 && proto_err)); // R11
  AST_STALL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_strb[A_STALL]) |-> ($stable(line_state) && $countones(act_strb) == 1)); // R9
  AST_FETCH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_strb[A_FETCH]) |-> ($past(line_state) == ST_IDLE)); // R3
  AST_WAKE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_strb[A_WAKE]) |-> (line_state == ST_IDLE || line_state == ST_SHR ||
                                         line_state == ST_OWN)); // R5
  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $onehot0(act_strb[A_FWD:A_DATA])); // R12
endmodule

// File: tb/l2_line_coh_ctrl_tb.sv
`timescale 1ns/1ps
module l2_line_coh_ctrl_tb;
  localparam int E_RD = 0, E_IF = 1, E_WR = 2, E_PUT = 3, E_EVD = 4, E_EVC = 5,
                 E_MD = 6, E_MA = 7, E_L1D = 8, E_AK = 9, E_AKL = 10, E_UNB = 11,
                 E_XUNB = 12, E_DINV = 13;
  localparam int S_NP = 0, S_SS = 1, S_M = 2, S_MT = 3, S_FX = 4, S_FS = 5, S_FM = 6,
                 S_SB = 7, S_MB = 8, S_OB = 9, S_W2 = 10, S_WD = 11, S_WU = 12,
                 S_EM = 13, S_EC = 14, S_ED = 15, S_EO = 16, S_EOC = 17;
  localparam int D = 1, X = 2, F = 4, I = 8, MF = 16, WB = 32, AK = 64, SL = 128,
                 P = 256, W = 512;

  logic clk = 0, rst_n = 0, ev_valid = 0;
  logic [3:0] ev_code = '0;
  logic ev_ready, act_valid, proto_err;
  logic [9:0] act_strb;
  logic [4:0] line_state;
  int checks = 0, errors = 0;
  logic exp_err = 0;

  int    q_st[$];
  int    q_act[$];
  int    q_err[$];
  string q_tag[$];

  always #2 clk = ~clk;

  l2_line_coh_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .act_valid(act_valid), .act_strb(act_strb),
    .line_state(line_state), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // driver: one event per cycle, expected result queued for the monitor
  task automatic send(input int code, input int st, input int act, input bit err_now,
                      input string tag);
    ev_valid = 1'b1;
    ev_code  = 4'(code);
    if (err_now) exp_err = 1'b1;
    q_st.push_back(st);
    q_act.push_back(act);
    q_err.push_back(int'(exp_err));
    q_tag.push_back(tag);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // monitor: compares each result pulse with the queued expectation
  always @(negedge clk) begin
    if (rst_n && act_valid) begin
      if (q_st.size() == 0) begin
        chk(1'b0, "R2", "unexpected act_valid", 1, 0);
      end else begin
        int es, ea, ee;
        string t;
        es = q_st.pop_front();
        ea = q_act.pop_front();
        ee = q_err.pop_front();
        t  = q_tag.pop_front();
        chk(int'(line_state) == es, t, "state", int'(line_state), es);
        chk(int'(act_strb) == ea, t, "strobes", int'(act_strb), ea);
        chk(int'(proto_err) == ee, t, "err", int'(proto_err), ee);
      end
    end
  end

  task automatic idle_check(input int st);
    @(negedge clk);
    @(negedge clk);
    chk(!act_valid, "R2", "idle act_valid", int'(act_valid), 0);
    chk(int'(line_state) == st, "R2", "idle state", int'(line_state), st);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(ev_ready, "R1", "ready", int'(ev_ready), 1);
    chk(line_state == 0, "R1", "state", int'(line_state), 0);
    chk(!act_valid, "R1", "act_valid", int'(act_valid), 0);
    chk(!proto_err, "R1", "err", int'(proto_err), 0);

    // exclusive fill, forwarded read, shared write, writeback, dirty eviction
    send(E_RD,   S_FX, MF|P,    0, "R3");
    send(E_MD,   S_OB, X|P,     0, "R5");
    send(E_RD,   S_OB, SL,      0, "R9");
    send(E_XUNB, S_MT, P|W,     0, "R5");
    send(E_RD,   S_W2, F|P,     0, "R6");
    send(E_L1D,  S_WU, P,       0, "R6");
    send(E_UNB,  S_SS, P|W,     0, "R6");
    send(E_RD,   S_SS, D|P,     0, "R12");
    send(E_WR,   S_SB, X|I|P,   0, "R12");
    send(E_XUNB, S_MT, P|W,     0, "R12");
    send(E_PUT,  S_M,  AK|P,    0, "R7");
    send(E_EVD,  S_EM, WB,      0, "R8");
    send(E_DINV, S_EM, P,       0, "R10");
    send(E_RD,   S_EM, SL,      0, "R9");
    send(E_MA,   S_NP, P|W,     0, "R8");
    idle_check(S_NP);

    // demotion to shared fill, clean shared eviction
    send(E_RD,   S_FX, MF|P,    0, "R3");
    send(E_IF,   S_FS, P,       0, "R4");
    send(E_RD,   S_FS, P,       0, "R4");
    send(E_MD,   S_SS, D|P|W,   0, "R4");
    send(E_EVC,  S_EC, I,       0, "R8");
    send(E_DINV, S_EC, P,       0, "R10");
    send(E_AK,   S_EC, P,       0, "R8");
    send(E_AKL,  S_EM, AK|P,    0, "R8");
    send(E_MA,   S_NP, P|W,     0, "R8");
    send(E_DINV, S_NP, P,       0, "R10");

    // write fill, reversed unblock/data order, dirty shared eviction
    send(E_WR,   S_FM, MF|P,    0, "R3");
    send(E_DINV, S_FM, SL,      0, "R9");
    send(E_MD,   S_OB, D|P,     0, "R5");
    send(E_XUNB, S_MT, P|W,     0, "R5");
    send(E_IF,   S_W2, F|P,     0, "R6");
    send(E_UNB,  S_WD, P,       0, "R6");
    send(E_L1D,  S_SS, P|W,     0, "R6");
    send(E_EVD,  S_ED, I,       0, "R8");
    send(E_AKL,  S_EM, WB|P,    0, "R8");
    send(E_MA,   S_NP, P|W,     0, "R8");

    // modified write, owned evictions clean and dirty
    send(E_IF,   S_FS, MF|P,    0, "R3");
    send(E_MD,   S_SS, D|P|W,   0, "R4");
    send(E_WR,   S_SB, X|I|P,   0, "R12");
    send(E_XUNB, S_MT, P|W,     0, "R5");
    send(E_PUT,  S_M,  AK|P,    0, "R7");
    send(E_WR,   S_MB, X|P,     0, "R5");
    send(E_XUNB, S_MT, P|W,     0, "R5");
    send(E_EVC,  S_EOC, I,      0, "R8");
    send(E_AK,   S_EOC, P,      0, "R8");
    send(E_AKL,  S_EM, AK|P,    0, "R8");
    send(E_MA,   S_NP, P|W,     0, "R8");
    send(E_RD,   S_FX, MF|P,    0, "R3");
    send(E_MD,   S_OB, X|P,     0, "R5");
    send(E_XUNB, S_MT, P|W,     0, "R5");
    send(E_EVD,  S_EO, I,       0, "R8");
    send(E_L1D,  S_EM, WB|P,    0, "R8");
    send(E_MA,   S_NP, P|W,     0, "R8");
    idle_check(S_NP);

    // illegal events and sticky error
    send(E_MA,   S_NP, 0,       1, "R11");
    send(E_RD,   S_FX, MF|P,    0, "R11");
    send(15,     S_FX, 0,       1, "R11");
    idle_check(S_FX);
    chk(q_st.size() == 0, "R2", "pending results", q_st.size(), 0);
    do_reset();
    chk(!proto_err, "R1", "err after reset", int'(proto_err), 0);
    chk(line_state == 0, "R1", "state after reset", int'(line_state), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule